// File: doc/BRIEF.md
# Video Register Port with Colour Palette

This block is the register window that a processor uses to reach a tile-based video chip. A processor drives one access at a time into four selectable registers: a control register, a read-only status register, an address register loaded by two writes in a row, and a data port. Every data-port write stores a byte at the current video address and then moves that address forward, either by one or by a wide stride. The control register picks the stride. Bytes aimed at the palette page go into an on-chip 32-entry colour memory. All other bytes go into a small byte-array stand-in for general video memory.

The status register shows a vertical-blank flag in bit 7. A frame-timing input sets this flag, and software polls it before it touches video memory. A status read also returns the address register to its "high byte next" state. In the palette, every fourth slot is an alias of the one shared backdrop colour. A write to any of those slots updates that single colour, and a read of any of them returns it.

The request side is a valid/ready channel, and `req_ready` is held high, so the channel never back-pressures. An access is taken in the same cycle as `req_valid`. A read is answered exactly one cycle later with a single-cycle `rsp_valid` pulse. That pulse cannot be stalled, so the requester must be able to take it. Writes get no response.

Top module: `vid_regport`

## Requirements
- R1: After reset the control register, the video address and every palette entry are zero, and the vblank flag is clear, so a status read returns 0x00.
- R2: The address register (select 2) takes two writes. The first write stages the upper 6 bits of the 14-bit address from data bits 5:0, and bits 7:6 are dropped. The second write supplies the low byte and loads the whole address. The video address does not change on the first write, and it changes only on address-register or data-port writes.
- R3: A status read (select 1) resets the write toggle, so the next address-register write is taken as the upper part.
- R4: A data-port write (select 3) stores the byte at the current video address and then advances the address by 1 when control (select 0) bit 2 is clear.
- R5: When control bit 2 is set, the advance is 32. The address is 14 bits wide and wraps modulo 2^14.
- R6: Addresses 0x3F00 to 0x3FFF reach the palette at entry index address[4:0], so the 32 entries repeat across the page.
- R7: Palette indices 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C alias entry 0x00, for writes and for the palette read port alike.
- R8: Palette entries keep only data bits 5:0.
- R9: A `vblank_set` pulse sets the flag. A status read returns the flag in bit 7, with bits 6:0 zero, and then clears it. If a set pulse coincides with a status read, the flag stays set.
- R10: `req_ready` is always high. Each accepted read gives `rsp_valid` for exactly one cycle, one cycle later, and writes give none. A read of select 0, 2 or 3 returns 0x00, and a write to select 1 has no effect.
- R11: A data-port write outside 0x3F00 to 0x3FFF stores the full byte in the stub array at address[5:0] and leaves the palette untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted (constant high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 control, 1 status, 2 address, 3 data |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| vblank_set | input | 1 | Frame-timing pulse that sets the vblank flag |
| ctrl_q | output | 8 | Current control register |
| vaddr | output | 14 | Current video address |
| pal_rd_idx | input | 5 | Palette lookup index for the pixel side |
| pal_rd_color | output | 6 | Palette colour at that index, alias folded |
| mem_rd_addr | input | 6 | Stub memory lookup address |
| mem_rd_data | output | 8 | Stub memory byte at that address |

## Verification
The bench uses the default parameters: a 14-bit address, 32 palette entries of 6 bits, a 64-byte stub and a wide stride of 32. With these values every palette slot and every stub byte can be written in a sweep and read back through the lookup ports, and each result is compared with values the bench computes. The small sizes also let a single address load near the top of the page reach the stride-32 wrap past 0x3FFF, land on an aliased slot, and reach the mirrored palette copies above 0x3F1F.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  // control bit that picks the wide address stride
  localparam int STEP_CTRL_BIT = 2;
  // status bit that carries the vertical-blank flag
  localparam int VBLANK_BIT = 7;
endpackage

// File: rtl/vrp_addr_unit.sv
module vrp_addr_unit #(
  parameter int ADDR_W    = 14,
  parameter int WIDE_STEP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic              stat_rd,
  input  logic              wide_step,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] vaddr,
  output logic              toggle
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_stage;
  logic [ADDR_W-1:0] step;

  assign step = wide_step ? ADDR_W'(WIDE_STEP) : ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr    <= '0;
      hi_stage <= '0;
      toggle   <= 1'b0;
    end else begin
      if (stat_rd) begin
        toggle <= 1'b0;
      end
      if (addr_wr) begin
        if (!toggle) begin
          hi_stage <= wdata[HI_W-1:0];
          toggle   <= 1'b1;
        end else begin
          vaddr  <= {hi_stage, wdata};
          toggle <= 1'b0;
        end
      end else if (data_wr) begin
        vaddr <= vaddr + step;
      end
    end
  end
endmodule

// File: rtl/vrp_palette.sv
module vrp_palette #(
  parameter int COLOR_W     = 6,
  parameter int DEPTH       = 32,
  parameter int ALIAS_EVERY = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [COLOR_W-1:0]       wr_color,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [COLOR_W-1:0]       rd_color
);
  localparam int IW = $clog2(DEPTH);
  localparam int GW = $clog2(ALIAS_EVERY);

  // any slot at a multiple of ALIAS_EVERY resolves to the backdrop entry
  function automatic logic [IW-1:0] fold(input logic [IW-1:0] idx);
    return (idx[GW-1:0] == '0) ? '0 : idx;
  endfunction

  logic [COLOR_W-1:0] ent [DEPTH];
  logic [IW-1:0]      wr_slot;

  assign wr_slot = fold(wr_idx);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if ((g % ALIAS_EVERY) == 0 && g != 0) begin : g_alias
      assign ent[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent[g] <= '0;
        end else if (wr_en && wr_slot == IW'(g)) begin
          ent[g] <= wr_color;
        end
      end
    end
  end

  assign rd_color = ent[fold(rd_idx)];
endmodule

// File: rtl/vrp_stub_mem.sv
module vrp_stub_mem #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int WORDS = 1 << AW;

  logic [7:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vrp_status.sv
module vrp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic stat_rd,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_pulse) begin
      flag <= 1'b1;
    end else if (stat_rd) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_regport.sv
module vid_regport #(
  parameter int ADDR_W      = 14,
  parameter int COLOR_W     = 6,
  parameter int PAL_DEPTH   = 32,
  parameter int ALIAS_EVERY = 4,
  parameter int STUB_AW     = 6,
  parameter int WIDE_STEP   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [1:0]                   req_sel,
  input  logic [7:0]                   req_wdata,
  output logic                         rsp_valid,
  output logic [7:0]                   rsp_data,
  input  logic                         vblank_set,
  output logic [7:0]                   ctrl_q,
  output logic [ADDR_W-1:0]            vaddr,
  input  logic [$clog2(PAL_DEPTH)-1:0] pal_rd_idx,
  output logic [COLOR_W-1:0]           pal_rd_color,
  input  logic [STUB_AW-1:0]           mem_rd_addr,
  output logic [7:0]                   mem_rd_data
);
  import vrp_pkg::*;

  localparam int PAL_IW = $clog2(PAL_DEPTH);
  localparam int PAGE_W = ADDR_W - 8;

  logic wr_ctrl, wr_addr, wr_data, rd_any, rd_stat;
  logic vblank_q, toggle_q, pal_hit;

  assign req_ready = 1'b1;
  assign wr_ctrl   = req_valid &  req_write & (req_sel == SEL_CTRL);
  assign wr_addr   = req_valid &  req_write & (req_sel == SEL_ADDR);
  assign wr_data   = req_valid &  req_write & (req_sel == SEL_DATA);
  assign rd_any    = req_valid & ~req_write;
  assign rd_stat   = rd_any & (req_sel == SEL_STAT);

  // palette page is the top page of the address space
  assign pal_hit   = (vaddr[ADDR_W-1:8] == {PAGE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) begin
        rsp_data <= rd_stat ? (8'(vblank_q) << VBLANK_BIT) : 8'h00;
      end
    end
  end

  vrp_addr_unit #(
    .ADDR_W   (ADDR_W),
    .WIDE_STEP(WIDE_STEP)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (wr_addr),
    .data_wr  (wr_data),
    .stat_rd  (rd_stat),
    .wide_step(ctrl_q[STEP_CTRL_BIT]),
    .wdata    (req_wdata),
    .vaddr    (vaddr),
    .toggle   (toggle_q)
  );

  vrp_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse(vblank_set),
    .stat_rd  (rd_stat),
    .flag     (vblank_q)
  );

  vrp_palette #(
    .COLOR_W    (COLOR_W),
    .DEPTH      (PAL_DEPTH),
    .ALIAS_EVERY(ALIAS_EVERY)
  ) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_data & pal_hit),
    .wr_idx  (vaddr[PAL_IW-1:0]),
    .wr_color(req_wdata[COLOR_W-1:0]),
    .rd_idx  (pal_rd_idx),
    .rd_color(pal_rd_color)
  );

  vrp_stub_mem #(
    .AW(STUB_AW)
  ) u_stub (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_data & ~pal_hit),
    .wr_addr(vaddr[STUB_AW-1:0]),
    .wr_data(req_wdata),
    .rd_addr(mem_rd_addr),
    .rd_data(mem_rd_data)
  );
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker #(
  parameter int ADDR_W    = 14,
  parameter int WIDE_STEP = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_sel,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              vblank_set,
  input logic [7:0]        ctrl_q,
  input logic [ADDR_W-1:0] vaddr,
  input logic              vblank_flag
);
  logic rd_acc, stat_rd, data_wr, addr_wr;
  assign rd_acc  = req_valid && !req_write;
  assign stat_rd = rd_acc && req_sel == 2'd1;
  assign data_wr = req_valid && req_write && req_sel == 2'd3;
  assign addr_wr = req_valid && req_write && req_sel == 2'd2;

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid); // R10
  AST_RESPONSE_PROMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc)); // R10
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[6:0] == 7'd0); // R9
  AST_VBLANK_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && vblank_flag) |=> rsp_data[7]); // R9
  AST_VBLANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !vblank_set) |=> !vblank_flag); // R9
  AST_STEP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ctrl_q[2]) |=> vaddr == ADDR_W'($past(vaddr) + ADDR_W'(1))); // R4
  AST_STEP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctrl_q[2]) |=> vaddr == ADDR_W'($past(vaddr) + ADDR_W'(WIDE_STEP))); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr || addr_wr) |=> $stable(vaddr)); // R2
endmodule

bind vid_regport vrp_checker #(
  .ADDR_W   (ADDR_W),
  .WIDE_STEP(WIDE_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_sel    (req_sel),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .vblank_set (vblank_set),
  .ctrl_q     (ctrl_q),
  .vaddr      (vaddr),
  .vblank_flag(vblank_q)
);

// File: tb/tb_vid_regport.sv
module tb_vid_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [1:0] req_sel = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       vblank_set = 1'b0;
  logic [7:0] ctrl_q;
  logic [13:0] vaddr;
  logic [4:0] pal_rd_idx = 5'd0;
  logic [5:0] pal_rd_color;
  logic [5:0] mem_rd_addr = 6'd0;
  logic [7:0] mem_rd_data;

  int n_chk = 0, n_fail = 0;
  logic [5:0] pal_m [32];
  logic [7:0] stub_m [64];

  always #10 clk = ~clk;

  vid_regport dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .vblank_set(vblank_set),
    .ctrl_q(ctrl_q), .vaddr(vaddr), .pal_rd_idx(pal_rd_idx),
    .pal_rd_color(pal_rd_color), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int fold(input int k);
    return (k % 4 == 0) ? 0 : k;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; d = rsp_data;
  endtask

  task automatic set_addr(input logic [13:0] a);
    logic [7:0] d; logic v;
    rd(2'd1, d, v);
    wr(2'd2, {2'b00, a[13:8]});
    wr(2'd2, a[7:0]);
  endtask

  task automatic data_wr_m(input logic [7:0] d);
    logic [13:0] a;
    a = vaddr;
    if (a[13:8] == 6'h3F) pal_m[fold(int'(a[4:0]))] = d[5:0];
    else stub_m[a[5:0]] = d;
    wr(2'd3, d);
  endtask

  task automatic check_palette(input string req);
    for (int k = 0; k < 32; k++) begin
      pal_rd_idx = 5'(k);
      #1;
      check(req, int'(pal_rd_color), int'(pal_m[fold(k)]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v;
    for (int k = 0; k < 32; k++) pal_m[k] = '0;
    for (int k = 0; k < 64; k++) stub_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 vaddr", int'(vaddr), 0);
    check("R1 ctrl", int'(ctrl_q), 0);
    check("R10 ready", int'(req_ready), 1);
    check_palette("R1 palette");
    rd(2'd1, d, v);
    check("R1 status", int'(d), 0);
    check("R10 rsp_valid on read", int'(v), 1);
    @(negedge clk);
    check("R10 rsp_valid single cycle", int'(rsp_valid), 0);

    // R2: two-write load, high bits 7:6 dropped
    wr(2'd2, 8'hFF);
    check("R2 first write holds vaddr", int'(vaddr), 0);
    check("R10 no response on write", int'(rsp_valid), 0);
    wr(2'd2, 8'h34);
    check("R2 loaded", int'(vaddr), 'h3F34);

    // R3: status read clears a half-done load
    rd(2'd1, d, v);
    wr(2'd2, 8'h12);
    rd(2'd1, d, v);
    wr(2'd2, 8'h3F);
    wr(2'd2, 8'h00);
    check("R3 toggle reset by status read", int'(vaddr), 'h3F00);

    // R4 R6 R7 R8: full palette sweep with step 1
    wr(2'd0, 8'h00);
    for (int i = 0; i < 32; i++) data_wr_m(8'((i * 7 + 'hC3) & 'hFF));
    check("R4 step one after sweep", int'(vaddr), 'h3F20);
    check_palette("R7 R8 palette sweep");

    // R6: mirrored palette page
    set_addr(14'h3F25);
    data_wr_m(8'h2A);
    set_addr(14'h3FE6);
    data_wr_m(8'hD5);
    check_palette("R6 page mirror");

    // R5: wide step and 14-bit wrap
    wr(2'd0, 8'h04);
    check("R5 ctrl", int'(ctrl_q), 'h04);
    set_addr(14'h3F01);
    data_wr_m(8'h11);
    check("R5 step 32", int'(vaddr), 'h3F21);
    data_wr_m(8'h22);
    check("R5 step 32 again", int'(vaddr), 'h3F41);
    set_addr(14'h3FF0);
    data_wr_m(8'h3C);
    check("R5 wrap", int'(vaddr), 'h0010);
    check_palette("R5 R7 wide writes");

    // R11: stub sweep with step 1
    wr(2'd0, 8'h00);
    set_addr(14'h0000);
    for (int i = 0; i < 64; i++) data_wr_m(8'((i * 13 + 5) & 'hFF));
    check("R4 stub sweep end", int'(vaddr), 64);
    set_addr(14'h1041);
    data_wr_m(8'hE7);
    for (int k = 0; k < 64; k++) begin
      mem_rd_addr = 6'(k);
      #1;
      check("R11 stub", int'(mem_rd_data), int'(stub_m[k]));
    end
    check_palette("R11 palette untouched");

    // R9: vblank flag
    @(negedge clk); vblank_set = 1'b1;
    @(negedge clk); vblank_set = 1'b0;
    rd(2'd1, d, v);
    check("R9 vblank seen", int'(d), 'h80);
    rd(2'd1, d, v);
    check("R9 vblank cleared", int'(d), 0);
    @(negedge clk); vblank_set = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = 2'd1;
    @(negedge clk);
    req_valid = 1'b0; vblank_set = 1'b0;
    check("R9 coincident read value", int'(rsp_data), 'h80);
    rd(2'd1, d, v);
    check("R9 set wins over clear", int'(d), 'h80);
    rd(2'd1, d, v);
    check("R9 cleared after", int'(d), 0);

    // R10: other reads return zero, status write ignored
    wr(2'd0, 8'h5A);
    rd(2'd0, d, v);
    check("R10 ctrl read zero", int'(d), 0);
    check("R10 ctrl read valid", int'(v), 1);
    rd(2'd3, d, v);
    check("R10 data read zero", int'(d), 0);
    wr(2'd1, 8'hFF);
    rd(2'd1, d, v);
    check("R10 status write ignored", int'(d), 0);
    check("R10 ctrl kept", int'(ctrl_q), 'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule